// File: doc/BRIEF.md
# EDO DRAM Start-up and Refresh Sequencer

This block sits between a simple host request/acknowledge port and an asynchronous 2M x 8 EDO DRAM with 2048 refresh rows. After reset it keeps every strobe high for a programmable pause, measured in clocks, that must cover at least 200 microseconds. It then runs a fixed number of CAS-before-RAS warm-up cycles, which advance the device's internal refresh counter, and raises `ready` when they finish. Until then no host request is accepted.

Once ready, an interval counter requests one CAS-before-RAS refresh every `REFI_CLKS` clocks. `REFI_CLKS` is the refresh period divided by 2048 rows. The sequencer serves a pending refresh before a new host access, but it never interrupts an access that has already started. A host access is a single read or a single early write. The 21-bit host address is split into an 11-bit row (upper bits) and a 10-bit column (lower bits), and these are presented one after the other on a shared address bus. Precharge, RAS-to-CAS delay, CAS width, RAS width and CAS-to-RAS lead are parameters in clocks, and each is enforced as a minimum.

Top module: `edo_dram_seq`

## Requirements
- R1: While `rst` is high and for at least `PAUSE_CLKS` clocks after it falls, `ras_n`, `cas_n`, `we_n` and `oe_n` stay high and `ready` stays low.
- R2: After the pause, exactly `WARMUP_CBR` refresh cycles are issued, then `ready` rises. No host access (RAS falling while CAS is high) and no `host_ack` occurs before `ready`.
- R3: In a refresh cycle, CAS falls exactly `T_CSR` clocks before RAS falls, `we_n` stays high, and RAS and CAS rise together.
- R4: After `ready`, one refresh is requested every `REFI_CLKS` clocks. The gap between consecutive refresh RAS falls never exceeds `REFI_CLKS` plus one access and one refresh length.
- R5: A pending refresh wins over a waiting host request, and an access in progress is never delayed. `host_ack` comes exactly `T_RCD+T_CAS` clocks after that access's RAS fall.
- R6: In an access, RAS falls with `host_addr[20:10]` on `dram_addr`. Exactly `T_RCD` clocks later CAS falls with `host_addr[9:0]` (zero-extended). The address then does not change again while RAS is low.
- R7: A write drives `we_n` low from the RAS fall, so it is low before CAS falls. `oe_n` stays high, `dq_oe` is high and `dq_out` carries the write data.
- R8: A read keeps `we_n` high until after RAS rises and holds `oe_n` low while CAS is low. `host_rdata` is the value of `dram_dq_in` at the clock edge that ends the CAS window.
- R9: RAS is high for at least `T_RP` clocks before every fall, and low for at least `T_RAS` clocks. CAS is low for at least `T_CAS` clocks in an access.
- R10: Each accepted request produces a single one-clock `host_ack` pulse, and read data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | Byte address: row [20:10], column [9:0] |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | 8 | Read data, valid with ack |
| ready | output | 1 | Start-up sequence complete |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from the memory |

## Verification
The hardest situation to reach from the ports is a refresh tick that lands while an access is running and another host request is already waiting. Only that case exercises both the priority rule and the no-interrupt rule. The ports give no direct view of when the interval counter expires. The bench therefore issues back-to-back reads and writes without pause over several refresh intervals, so the ticks fall in every phase of an access. A cycle-level memory model then checks refresh gaps, address stability and the timing from RAS to acknowledge on every cycle.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    localparam int ROW_W   = 11;
    localparam int COL_W   = 10;
    localparam int DATA_W  = 8;
    localparam int HADDR_W = ROW_W + COL_W;
    localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_ROW,
        EN_COL,
        EN_HOLD,
        EN_LEAD,
        EN_CBR,
        EN_PRE
    } eng_state_t;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WARM,
        PH_READY
    } init_phase_t;

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    function automatic int cnt_width(input int maxval);
        int w;
        w = $clog2(maxval + 1);
        return (w < 1) ? 1 : w;
    endfunction

    function automatic acc_req_t make_req(input logic wr,
                                          input logic [HADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d);
        acc_req_t r;
        r.wr    = wr;
        r.row   = a[HADDR_W-1:COL_W];
        r.col   = a[COL_W-1:0];
        r.wdata = d;
        return r;
    endfunction

    function automatic logic [PIN_W-1:0] pin_row(input logic [ROW_W-1:0] r);
        return PIN_W'(r);
    endfunction

    function automatic logic [PIN_W-1:0] pin_col(input logic [COL_W-1:0] c);
        return PIN_W'(c);
    endfunction

endpackage

// File: rtl/edo_init_ctl.sv
module edo_init_ctl
    import edo_seq_pkg::*;
#(
    parameter int PAUSE_CLKS = 20000,
    parameter int WARMUP_CBR = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cbr_done,
    output logic warm_req,
    output logic in_pause,
    output logic ready
);
    localparam int PW = cnt_width(PAUSE_CLKS);
    localparam int WW = cnt_width(WARMUP_CBR);

    init_phase_t     phase;
    logic [PW-1:0]   pause_cnt;
    logic [WW-1:0]   warm_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PAUSE;
            pause_cnt <= '0;
            warm_cnt  <= '0;
        end else begin
            case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == PW'(PAUSE_CLKS - 1)) phase <= PH_WARM;
                    else pause_cnt <= pause_cnt + 1'b1;
                end
                PH_WARM: begin
                    if (cbr_done) begin
                        if (warm_cnt == WW'(WARMUP_CBR - 1)) phase <= PH_READY;
                        warm_cnt <= warm_cnt + 1'b1;
                    end
                end
                default: phase <= PH_READY;
            endcase
        end
    end

    assign warm_req = (phase == PH_WARM);
    assign in_pause = (phase == PH_PAUSE);
    assign ready    = (phase == PH_READY);

    // R2
    warm_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (warm_cnt == WW'(WARMUP_CBR)));

endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer
    import edo_seq_pkg::*;
#(
    parameter int REFI_CLKS = 1560,
    parameter int OWED_W    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic done,
    output logic pending
);
    localparam int IW = cnt_width(REFI_CLKS);
    localparam logic [OWED_W-1:0] OWED_MAX = '1;

    logic [IW-1:0]     ivl;
    logic [OWED_W-1:0] owed;
    logic              tick;

    assign tick = run && (ivl == IW'(REFI_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) ivl <= '0;
        else if (tick)   ivl <= '0;
        else             ivl <= ivl + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            owed <= '0;
        end else begin
            case ({tick, done && (owed != '0)})
                2'b10:   if (owed != OWED_MAX) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign pending = (owed != '0);

    // R4
    owed_match_chk: assert property (@(posedge clk) disable iff (rst)
        (done && run) |-> (owed != '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (owed == OWED_MAX) |-> !$past(tick && run));

endmodule

// File: rtl/edo_cycle_engine.sv
module edo_cycle_engine
    import edo_seq_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RCD = 2,
    parameter int T_CAS = 2,
    parameter int T_RAS = 5,
    parameter int T_CSR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_go,
    input  logic              acc_go,
    input  acc_req_t          acc,
    output logic              ref_done,
    output logic              acc_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [PIN_W-1:0]  addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int TMAX = T_RP + T_RCD + T_CAS + T_RAS + T_CSR + 2;
    localparam int TW   = cnt_width(TMAX);
    localparam logic [TW-1:0] AGE_MAX = '1;

    eng_state_t      st;
    logic [TW-1:0]   cnt;
    logic [TW-1:0]   ras_age;
    logic [TW-1:0]   hi_age;
    logic            cur_wr;
    logic [COL_W-1:0] cur_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_age <= '0;
            hi_age  <= '0;
        end else begin
            if (ras_n) ras_age <= '0;
            else if (ras_age != AGE_MAX) ras_age <= ras_age + 1'b1;
            if (!ras_n) hi_age <= '0;
            else if (hi_age != AGE_MAX) hi_age <= hi_age + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= EN_IDLE;
            cnt      <= '0;
            ras_n    <= 1'b1;
            cas_n    <= 1'b1;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
            addr     <= '0;
            dq_out   <= '0;
            dq_oe    <= 1'b0;
            acc_ack  <= 1'b0;
            ref_done <= 1'b0;
            rd_data  <= '0;
            cur_wr   <= 1'b0;
            cur_col  <= '0;
        end else begin
            acc_ack  <= 1'b0;
            ref_done <= 1'b0;
            case (st)
                EN_IDLE: begin
                    if (ref_go) begin
                        st    <= EN_LEAD;
                        cas_n <= 1'b0;
                        cnt   <= TW'(T_CSR - 1);
                    end else if (acc_go) begin
                        st      <= EN_ROW;
                        ras_n   <= 1'b0;
                        addr    <= pin_row(acc.row);
                        we_n    <= ~acc.wr;
                        dq_oe   <= acc.wr;
                        dq_out  <= acc.wdata;
                        cur_wr  <= acc.wr;
                        cur_col <= acc.col;
                        cnt     <= TW'(T_RCD - 1);
                    end
                end
                EN_ROW: begin
                    if (cnt == '0) begin
                        st    <= EN_COL;
                        cas_n <= 1'b0;
                        addr  <= pin_col(cur_col);
                        oe_n  <= cur_wr;
                        cnt   <= TW'(T_CAS - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                EN_COL: begin
                    if (cnt == '0) begin
                        st      <= EN_HOLD;
                        cas_n   <= 1'b1;
                        oe_n    <= 1'b1;
                        acc_ack <= 1'b1;
                        if (!cur_wr) rd_data <= dq_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                EN_HOLD: begin
                    if (ras_age >= TW'(T_RAS - 1)) begin
                        st    <= EN_PRE;
                        ras_n <= 1'b1;
                        we_n  <= 1'b1;
                        dq_oe <= 1'b0;
                        cnt   <= TW'(T_RP - 1);
                    end
                end
                EN_LEAD: begin
                    if (cnt == '0) begin
                        st    <= EN_CBR;
                        ras_n <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                EN_CBR: begin
                    if (ras_age >= TW'(T_RAS - 1)) begin
                        st       <= EN_PRE;
                        ras_n    <= 1'b1;
                        cas_n    <= 1'b1;
                        ref_done <= 1'b1;
                        cnt      <= TW'(T_RP - 1);
                    end
                end
                EN_PRE: begin
                    if (cnt == '0) st <= EN_IDLE;
                    else cnt <= cnt - 1'b1;
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !$past(ras_n) && !$past(cas_n)) |-> $stable(addr));

    // R7
    early_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !we_n) |-> !$past(we_n));

    // R3
    cbr_we_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && ras_n) |-> we_n);

    // R3
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> (we_n && !$past(cas_n)));

    // R8
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> ras_n);

    // R9
    rp_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_age >= TW'(T_RP)));

    // R9
    ras_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (ras_age >= TW'(T_RAS)));

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        acc_ack |=> !acc_ack);

endmodule

// File: rtl/edo_dram_seq.sv
module edo_dram_seq
    import edo_seq_pkg::*;
#(
    parameter int PAUSE_CLKS = 20000,
    parameter int WARMUP_CBR = 8,
    parameter int REFI_CLKS  = 1560,
    parameter int T_RP       = 3,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int T_RAS      = 5,
    parameter int T_CSR      = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic               host_ack,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               ready,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic               dram_we_n,
    output logic               dram_oe_n,
    output logic [PIN_W-1:0]   dram_addr,
    output logic [DATA_W-1:0]  dram_dq_out,
    output logic               dram_dq_oe,
    input  logic [DATA_W-1:0]  dram_dq_in
);
    logic     warm_req;
    logic     in_pause;
    logic     ref_pending;
    logic     ref_done;
    logic     ref_go;
    logic     acc_go;
    acc_req_t acc;

    edo_init_ctl #(
        .PAUSE_CLKS (PAUSE_CLKS),
        .WARMUP_CBR (WARMUP_CBR)
    ) u_init (
        .clk      (clk),
        .rst      (rst),
        .cbr_done (ref_done),
        .warm_req (warm_req),
        .in_pause (in_pause),
        .ready    (ready)
    );

    edo_refresh_timer #(
        .REFI_CLKS (REFI_CLKS),
        .OWED_W    (3)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (ready),
        .done    (ref_done),
        .pending (ref_pending)
    );

    assign ref_go = warm_req || (ready && ref_pending);
    assign acc_go = ready && host_req;
    assign acc    = make_req(host_we, host_addr, host_wdata);

    edo_cycle_engine #(
        .T_RP  (T_RP),
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_RAS (T_RAS),
        .T_CSR (T_CSR)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ref_go   (ref_go),
        .acc_go   (acc_go),
        .acc      (acc),
        .ref_done (ref_done),
        .acc_ack  (host_ack),
        .rd_data  (host_rdata),
        .ras_n    (dram_ras_n),
        .cas_n    (dram_cas_n),
        .we_n     (dram_we_n),
        .oe_n     (dram_oe_n),
        .addr     (dram_addr),
        .dq_out   (dram_dq_out),
        .dq_oe    (dram_dq_oe),
        .dq_in    (dram_dq_in)
    );

    // R1
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        in_pause |-> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n));

    // R2
    ack_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> ready);

endmodule

// File: tb/tb_edo_dram_seq.sv
module tb_edo_dram_seq;
    import edo_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int P_PAUSE = 300;
    localparam int P_WARM  = 8;
    localparam int P_REFI  = 120;
    localparam int P_RP    = 3;
    localparam int P_RCD   = 2;
    localparam int P_CAS   = 2;
    localparam int P_RAS   = 6;
    localparam int P_CSR   = 1;
    localparam int SLACK   = 30;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               host_req = 1'b0;
    logic               host_we = 1'b0;
    logic [HADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0]  host_wdata = '0;
    logic               host_ack;
    logic [DATA_W-1:0]  host_rdata;
    logic               ready;
    logic               dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [PIN_W-1:0]   dram_addr;
    logic [DATA_W-1:0]  dram_dq_out;
    logic               dram_dq_oe;
    logic [DATA_W-1:0]  dq_drv = '0;

    edo_dram_seq #(
        .PAUSE_CLKS (P_PAUSE), .WARMUP_CBR (P_WARM), .REFI_CLKS (P_REFI),
        .T_RP (P_RP), .T_RCD (P_RCD), .T_CAS (P_CAS), .T_RAS (P_RAS), .T_CSR (P_CSR)
    ) dut (
        .clk (clk), .rst (rst),
        .host_req (host_req), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_ack (host_ack), .host_rdata (host_rdata),
        .ready (ready),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n),
        .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
        .dram_addr (dram_addr), .dram_dq_out (dram_dq_out),
        .dram_dq_oe (dram_dq_oe), .dram_dq_in (dq_drv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural memory and protocol monitor
    logic [DATA_W-1:0] mem [int];
    logic [DATA_W-1:0] sb  [int];
    bit   p_ras = 1, p_cas = 1, p_we = 1, p_rdy = 0;
    int   rel_cyc = 0, ras_fall_cyc = 0, ras_rise_cyc = 0, cas_fall_cyc = 0;
    int   cbr_cnt = 0, cbr_at_ready = -1, ready_cyc = -1, last_cbr = -1;
    int   first_act = -1, acc_fall = 0;
    bit   col_seen = 0, in_cbr = 0;
    logic [ROW_W-1:0] row_lat = '0;
    logic [PIN_W-1:0] col_lat = '0;

    always @(negedge clk) begin
        if (rst) begin
            p_ras = 1; p_cas = 1; p_we = 1; p_rdy = 0;
            col_seen = 0; in_cbr = 0;
        end else begin
            if (ready && !p_rdy) begin
                ready_cyc = cyc;
                cbr_at_ready = cbr_cnt;
            end
            if ((p_ras && !dram_ras_n) || (p_cas && !dram_cas_n)) begin
                if (first_act < 0) first_act = cyc;
            end
            if (p_cas && !dram_cas_n && dram_ras_n) cas_fall_cyc = cyc;
            if (p_ras && !dram_ras_n) begin
                check(cyc - ras_rise_cyc >= P_RP, "R9 precharge", cyc - ras_rise_cyc, P_RP);
                if (!dram_cas_n) begin
                    in_cbr = 1;
                    cbr_cnt++;
                    check(dram_we_n == 1'b1, "R3 we during refresh", dram_we_n, 1);
                    check(cyc - cas_fall_cyc == P_CSR, "R3 cas lead", cyc - cas_fall_cyc, P_CSR);
                    if (ready_cyc >= 0) begin
                        if (last_cbr < 0)
                            check(cyc - ready_cyc <= P_REFI + SLACK, "R4 first refresh",
                                  cyc - ready_cyc, P_REFI + SLACK);
                        else
                            check(cyc - last_cbr <= P_REFI + SLACK, "R4 refresh gap",
                                  cyc - last_cbr, P_REFI + SLACK);
                        last_cbr = cyc;
                    end
                end else begin
                    check(cbr_cnt >= P_WARM && ready, "R2 access before init", cbr_cnt, P_WARM);
                    row_lat = dram_addr[ROW_W-1:0];
                    acc_fall = cyc;
                    col_seen = 0;
                end
                ras_fall_cyc = cyc;
            end
            if (p_cas && !dram_cas_n && !dram_ras_n && !in_cbr) begin
                col_lat = dram_addr;
                col_seen = 1;
                check(cyc - ras_fall_cyc == P_RCD, "R6 ras-to-cas", cyc - ras_fall_cyc, P_RCD);
                if (!dram_we_n) begin
                    check(p_we == 1'b0, "R7 we before cas", p_we, 0);
                    check(dram_dq_oe && dram_oe_n, "R7 drive/oe", {dram_dq_oe, dram_oe_n}, 3);
                    mem[{row_lat, col_lat[COL_W-1:0]}] = dram_dq_out;
                end else begin
                    check(dram_oe_n == 1'b0, "R8 oe low on read", dram_oe_n, 0);
                    dq_drv = mem.exists({row_lat, col_lat[COL_W-1:0]}) ?
                             mem[{row_lat, col_lat[COL_W-1:0]}] : 8'h00;
                end
            end
            if (!dram_ras_n && col_seen && dram_addr != col_lat)
                check(0, "R6 address moved", dram_addr, col_lat);
            if (!p_ras && dram_ras_n) begin
                check(cyc - ras_fall_cyc >= P_RAS, "R9 ras width", cyc - ras_fall_cyc, P_RAS);
                if (in_cbr) check(dram_cas_n == 1'b1, "R3 joint release", dram_cas_n, 1);
                in_cbr = 0;
                col_seen = 0;
                ras_rise_cyc = cyc;
            end
            if (!p_cas && dram_cas_n && !dram_ras_n)
                check(cyc - cas_fall_cyc >= P_CAS || in_cbr, "R9 cas width", cyc - cas_fall_cyc, P_CAS);
            if (!dram_cas_n && p_cas) cas_fall_cyc = cyc;
            if (!p_we && dram_we_n && !dram_ras_n)
                check(0, "R8 we rose with ras low", 1, 0);
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_rdy = ready;
        end
    end

    task automatic host_xfer(input logic wr, input logic [HADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] q);
        int n;
        @(negedge clk);
        host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = d;
        n = 0;
        do begin @(negedge clk); n++; end while (!host_ack && n < 2000);
        q = host_rdata;
        check(host_ack, "R10 ack arrives", host_ack, 1);
        check(cyc - acc_fall == P_RCD + P_CAS, "R5 access not delayed", cyc - acc_fall, P_RCD + P_CAS);
        check(row_lat == a[HADDR_W-1:COL_W], "R6 row on pins", row_lat, a[HADDR_W-1:COL_W]);
        check(col_lat == PIN_W'(a[COL_W-1:0]), "R6 column on pins", col_lat, a[COL_W-1:0]);
        host_req = 1'b0;
        if (wr) sb[a] = d;
        @(negedge clk);
        check(!host_ack, "R10 single pulse", host_ack, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        check(!ready, "R1 ready low in reset", ready, 0);
        rst = 1'b0;
        rel_cyc = cyc;
    endtask

    task automatic t_init;
        logic [DATA_W-1:0] q;
        int ack_cyc;
        host_xfer(1'b1, 21'h0ABCD, 8'h5A, q);
        ack_cyc = cyc;
        check(first_act - rel_cyc >= P_PAUSE, "R1 pause length", first_act - rel_cyc, P_PAUSE);
        check(cbr_at_ready == P_WARM, "R2 warm-up count", cbr_at_ready, P_WARM);
        check(ready_cyc >= 0 && ack_cyc > ready_cyc, "R2 ack after ready", ack_cyc, ready_cyc);
    endtask

    task automatic t_write_read;
        logic [DATA_W-1:0] q;
        logic [HADDR_W-1:0] al [4];
        al[0] = 21'h000000; al[1] = 21'h1FFFFF; al[2] = 21'h0AAAAA; al[3] = 21'h155555;
        for (int i = 0; i < 4; i++) host_xfer(1'b1, al[i], 8'(8'h11 * (i + 3)), q);
        for (int i = 3; i >= 0; i--) begin
            host_xfer(1'b0, al[i], 8'h00, q);
            check(q == sb[al[i]], "R8 read data", q, sb[al[i]]);
        end
        host_xfer(1'b0, 21'h0ABCD, 8'h00, q);
        check(q == 8'h5A, "R8 early write readback", q, 8'h5A);
        host_xfer(1'b0, 21'h012345, 8'h00, q);
        check(q == 8'h00, "R8 unwritten location", q, 0);
    endtask

    task automatic t_idle_refresh;
        int c0, start;
        c0 = cbr_cnt; start = cyc;
        while (cyc < start + 4 * P_REFI) @(negedge clk);
        check(cbr_cnt - c0 >= 3 && cbr_cnt - c0 <= 5, "R4 idle refresh rate", cbr_cnt - c0, 4);
    endtask

    task automatic t_load_refresh;
        logic [DATA_W-1:0] q;
        int c0, start, k;
        c0 = cbr_cnt; start = cyc; k = 0;
        while (cyc < start + 6 * P_REFI) begin
            host_xfer(k[0], HADDR_W'(k * 1031), 8'(k), q);
            if (!k[0] && sb.exists(HADDR_W'(k * 1031)))
                check(q == sb[HADDR_W'(k * 1031)], "R8 data under load", q, sb[HADDR_W'(k * 1031)]);
            k++;
        end
        check(cbr_cnt - c0 >= 5, "R5 refresh wins under load", cbr_cnt - c0, 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_init();
        t_write_read();
        t_idle_refresh();
        t_load_refresh();
        t_idle_refresh();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule